// File: doc/BRIEF.md
# Conditional-Operation Sequence Expander

The block takes one conditional request at a time and turns it into a short run of 32-bit register-register instruction words. The instruction set it targets has only two conditional primitives. The first is "zero unless the condition is nonzero". The second is "zero if the condition is nonzero". Each primitive takes a value register and a condition register. A request names an operation, a polarity and five register indices:

- destination
- first source
- second source
- condition
- scratch

The block then produces the two or three words that compute `rd = cond ? (rs1 op rs2) : rs1` for the arithmetic and logic operations, and `rd = cond ? rs1 : rs2` for select. `cond` means "condition register is zero" for the if-zero polarity and "condition register is nonzero" for the if-nonzero polarity.

Requests enter on a valid/ready handshake, and a request is taken in any cycle where both `req_valid` and `req_ready` are high. Words leave on a second valid/ready stream, one word per cycle where `out_valid` and `out_ready` are both high. `out_last` marks the final word and `out_idx` gives each word's position in its sequence. The consumer may hold `out_ready` low for any number of cycles, and the pending word waits for it. Correct results need distinct register indices. The destination is written before the first source is read again in the and-form, and before the second source and condition are read again in the select form.

Top module: `cond_seq_expander`

## Requirements
- R1: After reset `out_valid` is 0, `req_err` is 0 and `req_ready` is 1.
- R2: Operation codes are add=0, sub=1, or=2, xor=3, and=4, select=5, and `req_nz`=1 selects the if-nonzero polarity. For add, sub, or and xor the block emits two words. Word 0 is a conditional zero with value rs2, condition rc and destination rd. It uses the zero-if-nonzero form for the if-zero polarity and the zero-if-zero form for the if-nonzero polarity. Word 1 is `op rd, rs1, rd`.
- R3: For and, the block emits three words: `and rd, rs1, rs2`, then a conditional zero of rs1 into tmp with condition rc, then `or rd, rd, tmp`. The middle word uses the zero-if-zero form for the if-zero polarity and the zero-if-nonzero form for the if-nonzero polarity.
- R4: For select, the block emits three words. For the if-zero polarity they are: zero-if-nonzero of rs1 into rd, zero-if-zero of rs2 into tmp, then `or rd, rd, tmp`. The if-nonzero polarity swaps the two conditional-zero forms.
- R5: Every word is laid out as {funct7[31:25], rs2[24:20], rs1[19:15], funct3[14:12], rd[11:7], opcode[6:0]} with opcode 0x33. The conditional-zero words use funct7 0x07, with funct3 101 for zero-if-zero and 111 for zero-if-nonzero, the value in the rs1 field and the condition in the rs2 field. add, sub, or, xor and and use funct7/funct3 of 0x00/000, 0x20/000, 0x00/110, 0x00/100 and 0x00/111.
- R6: The first word of a sequence is valid in the cycle after acceptance with `out_idx`=0. `out_idx` rises by one per taken word. `out_last` is high only on word 1 of two-word forms and on word 2 of three-word forms.
- R7: `req_ready` is low from the cycle after acceptance until the last word is taken. It is high again in the following cycle.
- R8: While `out_valid` is high and `out_ready` is low, `out_word`, `out_idx` and `out_last` stay unchanged and `out_valid` stays high.
- R9: Operation codes 6 and 7 are accepted, raise `req_err` for exactly the next cycle and emit no word.
- R10: Running the emitted words in order on a register file gives, in rd, the conditional expression that the request names.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request |
| req_op | input | 3 | Operation code |
| req_nz | input | 1 | 1 = if-nonzero polarity, 0 = if-zero |
| req_rd | input | 5 | Destination register index |
| req_rs1 | input | 5 | First source register index |
| req_rs2 | input | 5 | Second source register index |
| req_rc | input | 5 | Condition register index |
| req_tmp | input | 5 | Scratch register index |
| req_err | output | 1 | One-cycle pulse for an unsupported operation |
| out_valid | output | 1 | Instruction word present |
| out_ready | input | 1 | Consumer takes the word |
| out_word | output | 32 | Instruction word |
| out_idx | output | 2 | Position of the word in its sequence |
| out_last | output | 1 | Final word of the sequence |

## Verification
An accepted request shows its first word, or its error pulse, one clock after the accepting edge. Each later word follows one clock after the edge that took the previous word. `req_ready` comes back one clock after the edge that takes the last word. The bench drives inputs and samples outputs on falling edges, so every check lands half a period after the edge that produced the value. The stall scenario holds `out_ready` low over several falling edges and compares each sample with the first. The end result is checked by decoding the collected words and running them on a behavioural register file.

// File: rtl/cseq_pkg.sv
`timescale 1ns/1ps
package cseq_pkg;
  localparam int ILEN      = 32;
  localparam int RIDX_W    = 5;
  localparam int MAX_WORDS = 3;
  localparam int IDX_W     = $clog2(MAX_WORDS);
  localparam int OP_W      = 3;

  localparam logic [OP_W-1:0] OP_ADD = 3'd0;
  localparam logic [OP_W-1:0] OP_SUB = 3'd1;
  localparam logic [OP_W-1:0] OP_OR  = 3'd2;
  localparam logic [OP_W-1:0] OP_XOR = 3'd3;
  localparam logic [OP_W-1:0] OP_AND = 3'd4;
  localparam logic [OP_W-1:0] OP_SEL = 3'd5;

  localparam logic [6:0] OPC_REG  = 7'h33;
  localparam logic [6:0] F7_PLAIN = 7'h00;
  localparam logic [6:0] F7_NEG   = 7'h20;
  localparam logic [6:0] F7_CZ    = 7'h07;
  localparam logic [2:0] F3_ADD   = 3'b000;
  localparam logic [2:0] F3_XOR   = 3'b100;
  localparam logic [2:0] F3_OR    = 3'b110;
  localparam logic [2:0] F3_AND   = 3'b111;
  localparam logic [2:0] F3_CZ_EQ = 3'b101;
  localparam logic [2:0] F3_CZ_NE = 3'b111;

  typedef logic [ILEN-1:0]   word_t;
  typedef logic [RIDX_W-1:0] ridx_t;

  function automatic word_t rtype(input logic [6:0] f7, input ridx_t b,
                                  input ridx_t a, input logic [2:0] f3,
                                  input ridx_t d);
    return {f7, b, a, f3, d, OPC_REG};
  endfunction

  // zero_if_nz = 1 : result is zero when the condition is nonzero
  function automatic word_t czero(input logic zero_if_nz, input ridx_t d,
                                  input ridx_t val, input ridx_t cnd);
    return rtype(F7_CZ, cnd, val, zero_if_nz ? F3_CZ_NE : F3_CZ_EQ, d);
  endfunction
endpackage

// File: rtl/cseq_alu_sel.sv
`timescale 1ns/1ps
module cseq_alu_sel
  import cseq_pkg::*;
(
  input  logic [OP_W-1:0] op,
  output logic [6:0]      f7,
  output logic [2:0]      f3
);
  always_comb begin
    f7 = F7_PLAIN;
    f3 = F3_ADD;
    case (op)
      OP_SUB: f7 = F7_NEG;
      OP_OR:  f3 = F3_OR;
      OP_XOR: f3 = F3_XOR;
      default: ;
    endcase
  end
endmodule

// File: rtl/cseq_plan.sv
`timescale 1ns/1ps
module cseq_plan
  import cseq_pkg::*;
(
  input  logic [OP_W-1:0]                op,
  input  logic                           nz,
  input  ridx_t                          rd,
  input  ridx_t                          rs1,
  input  ridx_t                          rs2,
  input  ridx_t                          rc,
  input  ridx_t                          tmp,
  output logic [MAX_WORDS-1:0][ILEN-1:0] words,
  output logic [IDX_W-1:0]               last_idx,
  output logic                           ok
);
  logic [6:0] alu_f7;
  logic [2:0] alu_f3;

  cseq_alu_sel u_alu (.op(op), .f7(alu_f7), .f3(alu_f3));

  always_comb begin
    words    = '0;
    last_idx = IDX_W'(1);
    ok       = 1'b1;
    case (op)
      OP_ADD, OP_SUB, OP_OR, OP_XOR: begin
        // if-zero keeps rs2 only when rc == 0: zero it when rc is nonzero
        words[0] = czero(!nz, rd, rs2, rc);
        words[1] = rtype(alu_f7, rd, rs1, alu_f3, rd);
      end
      OP_AND: begin
        words[0] = rtype(F7_PLAIN, rs2, rs1, F3_AND, rd);
        words[1] = czero(nz, tmp, rs1, rc);
        words[2] = rtype(F7_PLAIN, tmp, rd, F3_OR, rd);
        last_idx = IDX_W'(2);
      end
      OP_SEL: begin
        words[0] = czero(!nz, rd, rs1, rc);
        words[1] = czero(nz, tmp, rs2, rc);
        words[2] = rtype(F7_PLAIN, tmp, rd, F3_OR, rd);
        last_idx = IDX_W'(2);
      end
      default: ok = 1'b0;
    endcase
  end
endmodule

// File: rtl/cseq_emit.sv
`timescale 1ns/1ps
module cseq_emit
  import cseq_pkg::*;
(
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           take,
  input  logic                           good,
  input  logic [MAX_WORDS-1:0][ILEN-1:0] words_in,
  input  logic [IDX_W-1:0]               last_in,
  output logic                           busy,
  output logic                           err,
  input  logic                           out_ready,
  output word_t                          out_word,
  output logic [IDX_W-1:0]               out_idx,
  output logic                           out_last
);
  logic [MAX_WORDS-1:0][ILEN-1:0] hold_q;
  logic [IDX_W-1:0]               idx_q, last_q;
  logic                           busy_q, err_q;
  logic                           load, at_end;

  assign load   = take && good;
  assign at_end = (idx_q == last_q);

  for (genvar g = 0; g < MAX_WORDS; g++) begin : g_hold
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    hold_q[g] <= '0;
      else if (load) hold_q[g] <= words_in[g];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      last_q <= '0;
      err_q  <= 1'b0;
    end else begin
      err_q <= take && !good;
      if (load) begin
        busy_q <= 1'b1;
        idx_q  <= '0;
        last_q <= last_in;
      end else if (busy_q && out_ready) begin
        if (at_end) busy_q <= 1'b0;
        else        idx_q  <= idx_q + IDX_W'(1);
      end
    end
  end

  always_comb begin
    out_word = hold_q[0];
    for (int i = 1; i < MAX_WORDS; i++)
      if (idx_q == IDX_W'(i)) out_word = hold_q[i];
  end

  assign busy     = busy_q;
  assign err      = err_q;
  assign out_idx  = idx_q;
  assign out_last = busy_q && at_end;
endmodule

// File: rtl/cond_seq_expander.sv
`timescale 1ns/1ps
module cond_seq_expander
  import cseq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [OP_W-1:0]   req_op,
  input  logic              req_nz,
  input  logic [RIDX_W-1:0] req_rd,
  input  logic [RIDX_W-1:0] req_rs1,
  input  logic [RIDX_W-1:0] req_rs2,
  input  logic [RIDX_W-1:0] req_rc,
  input  logic [RIDX_W-1:0] req_tmp,
  output logic              req_err,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ILEN-1:0]   out_word,
  output logic [IDX_W-1:0]  out_idx,
  output logic              out_last
);
  logic [MAX_WORDS-1:0][ILEN-1:0] plan_words;
  logic [IDX_W-1:0]               plan_last;
  logic                           plan_ok, busy, take;

  assign req_ready = !busy;
  assign take      = req_valid && req_ready;
  assign out_valid = busy;

  cseq_plan u_plan (
    .op(req_op), .nz(req_nz), .rd(req_rd), .rs1(req_rs1), .rs2(req_rs2),
    .rc(req_rc), .tmp(req_tmp), .words(plan_words), .last_idx(plan_last),
    .ok(plan_ok)
  );

  cseq_emit u_emit (
    .clk(clk), .rst_n(rst_n), .take(take), .good(plan_ok),
    .words_in(plan_words), .last_in(plan_last), .busy(busy), .err(req_err),
    .out_ready(out_ready), .out_word(out_word), .out_idx(out_idx),
    .out_last(out_last)
  );
endmodule

// File: rtl/cond_seq_expander_chk.sv
`timescale 1ns/1ps
module cond_seq_expander_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic        req_err,
  input logic        out_valid,
  input logic        out_ready,
  input logic [31:0] out_word,
  input logic [1:0]  out_idx,
  input logic        out_last
);
  p_opcode_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_word[6:0] == 7'h33);

  p_idx_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_idx <= 2'd2) && (out_idx != 2'd2 || out_last)
                  && !(out_last && out_idx == 2'd0));

  p_idx_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !out_last |=>
      out_valid && out_idx == $past(out_idx) + 2'd1);

  p_ready_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !req_ready);

  p_ready_back_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && out_last |=> req_ready && !out_valid);

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=>
      out_valid && $stable(out_word) && $stable(out_idx) && $stable(out_last));

  p_err_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_err |-> $past(req_valid && req_ready) && !out_valid);
endmodule

bind cond_seq_expander cond_seq_expander_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_err(req_err), .out_valid(out_valid), .out_ready(out_ready),
  .out_word(out_word), .out_idx(out_idx), .out_last(out_last)
);

// File: tb/cond_seq_expander_tb.sv
`timescale 1ns/1ps
module cond_seq_expander_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_nz = 1'b0, out_ready = 1'b0;
  logic [2:0]  req_op = '0;
  logic [4:0]  req_rd = '0, req_rs1 = '0, req_rs2 = '0, req_rc = '0, req_tmp = '0;
  logic        req_ready, req_err, out_valid, out_last;
  logic [31:0] out_word;
  logic [1:0]  out_idx;

  int total = 0, bad = 0;
  logic [31:0] rf [32];
  logic [31:0] got [3];

  always #5 clk = ~clk;

  cond_seq_expander u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_nz(req_nz), .req_rd(req_rd), .req_rs1(req_rs1),
    .req_rs2(req_rs2), .req_rc(req_rc), .req_tmp(req_tmp), .req_err(req_err),
    .out_valid(out_valid), .out_ready(out_ready), .out_word(out_word),
    .out_idx(out_idx), .out_last(out_last)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] rw(input logic [6:0] f7, input logic [4:0] b,
      input logic [4:0] a, input logic [2:0] f3, input logic [4:0] d);
    return {f7, b, a, f3, d, 7'h33};
  endfunction

  // zero-if-zero : funct3 101, zero-if-nonzero : funct3 111 (R5)
  function automatic logic [31:0] cz(input bit ne, input logic [4:0] d,
      input logic [4:0] v, input logic [4:0] c);
    return rw(7'h07, c, v, ne ? 3'b111 : 3'b101, d);
  endfunction

  function automatic int seq_len(input logic [2:0] op);
    return (op < 3'd4) ? 2 : 3;
  endfunction

  function automatic logic [31:0] exp_word(input logic [2:0] op, input bit nz, input int k);
    logic [6:0] f7; logic [2:0] f3;
    f7 = (op == 3'd1) ? 7'h20 : 7'h00;
    f3 = (op == 3'd2) ? 3'b110 : (op == 3'd3) ? 3'b100 : 3'b000;
    if (op < 3'd4) // R2
      return (k == 0) ? cz(!nz, req_rd, req_rs2, req_rc) : rw(f7, req_rd, req_rs1, f3, req_rd);
    if (k == 2) return rw(7'h00, req_tmp, req_rd, 3'b110, req_rd);
    if (op == 3'd4) // R3
      return (k == 0) ? rw(7'h00, req_rs2, req_rs1, 3'b111, req_rd) : cz(nz, req_tmp, req_rs1, req_rc);
    return (k == 0) ? cz(!nz, req_rd, req_rs1, req_rc) : cz(nz, req_tmp, req_rs2, req_rc); // R4
  endfunction

  task automatic exec(input logic [31:0] w);
    logic [31:0] a, b, r;
    a = rf[w[19:15]]; b = rf[w[24:20]]; r = 'x;
    case ({w[31:25], w[14:12]})
      {7'h00, 3'b000}: r = a + b;
      {7'h20, 3'b000}: r = a - b;
      {7'h00, 3'b110}: r = a | b;
      {7'h00, 3'b100}: r = a ^ b;
      {7'h00, 3'b111}: r = a & b;
      {7'h07, 3'b101}: r = (b == 0) ? 32'd0 : a;
      {7'h07, 3'b111}: r = (b != 0) ? 32'd0 : a;
      default: ;
    endcase
    if (w[11:7] != 0) rf[w[11:7]] = r;
  endtask

  function automatic logic [31:0] intent(input logic [2:0] op, input bit nz,
      input logic [31:0] a, input logic [31:0] b, input logic [31:0] c);
    bit t;
    t = nz ? (c != 0) : (c == 0);
    case (op)
      3'd0: return t ? a + b : a;
      3'd1: return t ? a - b : a;
      3'd2: return t ? (a | b) : a;
      3'd3: return t ? (a ^ b) : a;
      3'd4: return t ? (a & b) : a;
      default: return t ? a : b;
    endcase
  endfunction

  task automatic set_req(input logic [2:0] op, input bit nz, input logic [4:0] d,
      input logic [4:0] s1, input logic [4:0] s2, input logic [4:0] c, input logic [4:0] t);
    req_op = op; req_nz = nz; req_rd = d; req_rs1 = s1; req_rs2 = s2; req_rc = c; req_tmp = t;
  endtask

  // Entered on a falling edge with the first word visible; drains it with out_ready high.
  task automatic drain(input logic [2:0] op, input bit nz);
    int n;
    n = seq_len(op);
    for (int k = 0; k < n; k++) begin
      chk($sformatf("R6 valid op%0d w%0d", op, k), {31'd0, out_valid}, 32'd1);
      chk($sformatf("R6 idx op%0d w%0d", op, k), {30'd0, out_idx}, k);
      chk($sformatf("R6 last op%0d w%0d", op, k), {31'd0, out_last}, {31'd0, k == n - 1});
      chk($sformatf("R7 ready low op%0d w%0d", op, k), {31'd0, req_ready}, 32'd0);
      chk($sformatf("R2/R3/R4/R5 word op%0d nz%0d w%0d", op, nz, k), out_word, exp_word(op, nz, k));
      got[k] = out_word;
      @(negedge clk);
    end
    chk($sformatf("R7 ready back op%0d", op), {31'd0, req_ready}, 32'd1);
    chk($sformatf("R6 idle op%0d", op), {31'd0, out_valid}, 32'd0);
  endtask

  task automatic t_reset;
    chk("R1 out_valid", {31'd0, out_valid}, 32'd0);
    chk("R1 req_err", {31'd0, req_err}, 32'd0);
    chk("R1 req_ready", {31'd0, req_ready}, 32'd1);
  endtask

  task automatic t_seq(input logic [2:0] op, input bit nz, input logic [31:0] cv);
    logic [31:0] a, b;
    a = 32'h1234_5678 + {29'd0, op} * 32'h0101_0101;
    b = 32'h0F0F_3C3C ^ {29'd0, op};
    for (int i = 0; i < 32; i++) rf[i] = 32'hA5A5_0000 + i;
    rf[0] = 0;
    set_req(op, nz, 5'd5, 5'd6, 5'd7, 5'd8, 5'd9);
    rf[6] = a; rf[7] = b; rf[8] = cv;
    out_ready = 1'b1; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    drain(op, nz);
    for (int k = 0; k < seq_len(op); k++) exec(got[k]);
    chk($sformatf("R10 result op%0d nz%0d c=%h", op, nz, cv), rf[5], intent(op, nz, a, b, cv));
  endtask

  task automatic t_stall;
    logic [31:0] w0;
    set_req(3'd5, 1'b1, 5'd12, 5'd3, 5'd17, 5'd30, 5'd1);
    out_ready = 1'b0; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    w0 = out_word;
    chk("R4 stalled first word", w0, exp_word(3'd5, 1'b1, 0));
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R8 held valid", {31'd0, out_valid}, 32'd1);
      chk("R8 held word", out_word, w0);
      chk("R8 held idx", {30'd0, out_idx}, 32'd0);
    end
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    chk("R8 advance after stall", {30'd0, out_idx}, 32'd1);
    @(negedge clk);
    chk("R8 idx held mid", {30'd0, out_idx}, 32'd1);
    out_ready = 1'b1;
    @(negedge clk);
    chk("R6 last after stall", {31'd0, out_last}, 32'd1);
    chk("R4 final word", out_word, exp_word(3'd5, 1'b1, 2));
    @(negedge clk);
    chk("R7 ready after stalled seq", {31'd0, req_ready}, 32'd1);
  endtask

  task automatic t_back_to_back;
    set_req(3'd1, 1'b0, 5'd20, 5'd21, 5'd22, 5'd23, 5'd24);
    out_ready = 1'b1; req_valid = 1'b1;
    @(negedge clk);
    set_req(3'd3, 1'b1, 5'd2, 5'd4, 5'd6, 5'd8, 5'd10);
    chk("R7 held request blocked w0", {31'd0, req_ready}, 32'd0);
    chk("R2 first seq w0", out_word, rw(7'h07, 5'd23, 5'd22, 3'b111, 5'd20));
    @(negedge clk);
    chk("R7 held request blocked w1", {31'd0, req_ready}, 32'd0);
    chk("R2 first seq w1", out_word, rw(7'h20, 5'd20, 5'd21, 3'b000, 5'd20));
    @(negedge clk);
    chk("R7 ready for held request", {31'd0, req_ready}, 32'd1);
    chk("R7 no word between", {31'd0, out_valid}, 32'd0);
    @(negedge clk);
    req_valid = 1'b0;
    drain(3'd3, 1'b1);
  endtask

  task automatic t_bad_op(input logic [2:0] op);
    set_req(op, 1'b0, 5'd5, 5'd6, 5'd7, 5'd8, 5'd9);
    out_ready = 1'b1; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk($sformatf("R9 err pulse op%0d", op), {31'd0, req_err}, 32'd1);
    chk($sformatf("R9 no word op%0d", op), {31'd0, out_valid}, 32'd0);
    chk($sformatf("R9 still ready op%0d", op), {31'd0, req_ready}, 32'd1);
    @(negedge clk);
    chk($sformatf("R9 err ends op%0d", op), {31'd0, req_err}, 32'd0);
    chk($sformatf("R9 still no word op%0d", op), {31'd0, out_valid}, 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    for (int op = 0; op < 6; op++)
      for (int nz = 0; nz < 2; nz++) begin
        t_seq(3'(op), nz[0], 32'd0);
        t_seq(3'(op), nz[0], 32'h0000_0040);
      end
    t_stall();
    t_back_to_back();
    t_bad_op(3'd6);
    t_bad_op(3'd7);
    t_seq(3'd4, 1'b1, 32'h8000_0000);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule